// File: doc/BRIEF.md
# Two-Byte Serial Register Port

This block is a synchronous serial slave that gives a host controller access to a bank of up to 64 byte-wide registers. A host frames each access by pulling an active-low select line low, clocks out one command byte and then one data byte on a serial clock that idles high, and releases the select line. Bits move least significant first. The port samples incoming bits and launches outgoing bits on the falling serial clock edge. The serial clock, the select line and the data line are treated as inputs synchronous to the core clock. Each falling edge is detected one core clock after it happens.

The command byte carries a 6-bit register address, a spare bit and a read/write flag. A write ends in a one-cycle strobe toward the register bank. A read captures the addressed register and shifts it back out during the data byte. A routing input chooses one of two pin arrangements. In the first, one pin carries data in both directions. In the second, the first pin only receives and a second pin only transmits. The bit timing is the same in both arrangements.

Top module: `serial_reg_port`

## Requirements
- R1: While `cs_n` is low, each falling `sclk` edge seen by the core clock shifts in one bit. The first 8 edges form the command byte and edges 9 to 16 form the data byte. The `reg_addr` output carries the command's address field.
- R2: Command bits arrive in this order: bit 0 to bit 5 are address bits A0 to A5, bit 6 is a spare bit, and bit 7 selects the access (1 = read, 0 = write). The spare bit has no effect on the access.
- R3: On a write, `reg_wr` is high for exactly one core clock, in the cycle after the 16th falling edge is sampled. In that cycle `reg_addr` holds the address and `reg_wdata` holds the data byte, assembled least significant bit first.
- R4: On a read, `reg_rdata` is captured when the 8th falling edge is sampled. Bit 0 of the captured byte appears on the output after that edge, and each later falling edge advances the output by one bit.
- R5: The output enable is high only after the read flag has been taken and only while `cs_n` is low. It drops in the same cycle that `cs_n` goes high.
- R6: With `split_pins` = 0, read data leaves on pin 1 (`data1_oe`) and `data2_oe` stays 0. With `split_pins` = 1, `data1_oe` stays 0 and read data leaves on pin 2 (`data2_oe`). Input bits are taken from `data1_i` in both cases.
- R7: If `cs_n` rises before the 16th edge, the transfer is abandoned with no write. The next low level of `cs_n` starts a fresh command byte.
- R8: Falling edges after the 16th in one select period are ignored. They cause no second strobe and they do not change the written data.
- R9: After reset, no output enable and no write strobe is active.
- R10: `sclk` edges while `cs_n` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low transfer select |
| split_pins | input | 1 | 0: one bidirectional pin, 1: separate receive and transmit pins |
| data1_i | input | 1 | Serial data into the port |
| data1_o | output | 1 | Serial data out on pin 1 |
| data1_oe | output | 1 | Output enable for pin 1 |
| data2_o | output | 1 | Serial data out on pin 2 |
| data2_oe | output | 1 | Output enable for pin 2 |
| reg_addr | output | 6 | Register address from the command byte |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data byte |
| reg_rdata | input | 8 | Read data from the addressed register |

## Verification
The bench builds the block at its only configuration: 8-bit bytes, a 16-edge frame and a 6-bit address. This lets it reach both ends of the address range (0 and 63), both settings of the spare bit, and both pin arrangements for reads and writes. The fixed frame length lets it place select-line releases at exact edge counts: after 12 and after 15 edges for aborted writes, and after 20 edges for over-long frames. A behavioural model predicts the strobe, the enables and the shifted-out bit on every core clock.

// File: rtl/serial_reg_port.sv
module serial_reg_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       split_pins,
  input  logic       data1_i,
  output logic       data1_o,
  output logic       data1_oe,
  output logic       data2_o,
  output logic       data2_oe,
  output logic [5:0] reg_addr,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;
  localparam int FRAME  = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(FRAME + 1);
  localparam int IDX_W  = $clog2(BYTE_W);
  localparam int RW_BIT = BYTE_W - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  logic              sclk_q;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] cmd, wdat, tx;
  logic              drive;

  wire              fall   = sclk_q & ~sclk & ~cs_n & (cnt < CNT_W'(FRAME));
  wire              in_cmd = cnt < CNT_W'(BYTE_W);
  wire [IDX_W-1:0]  idx    = cnt[IDX_W-1:0];
  wire              oe     = drive & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      cnt    <= '0;
      cmd    <= '0;
      wdat   <= '0;
      tx     <= '0;
      drive  <= 1'b0;
      reg_wr <= 1'b0;
    end else begin
      sclk_q <= sclk;
      reg_wr <= 1'b0;
      if (cs_n) begin
        cnt   <= '0;
        drive <= 1'b0;
      end else if (fall) begin
        cnt <= cnt + CNT_W'(1);
        if (in_cmd) begin
          cmd[idx] <= data1_i;
          if (idx == LAST_IDX && data1_i) begin
            tx    <= reg_rdata;
            drive <= 1'b1;
          end
        end else if (cmd[RW_BIT]) begin
          tx <= {1'b0, tx[BYTE_W-1:1]};
        end else begin
          wdat[idx] <= data1_i;
          if (idx == LAST_IDX) reg_wr <= 1'b1;
        end
      end
    end
  end

  assign reg_addr  = cmd[ADDR_W-1:0];
  assign reg_wdata = wdat;
  assign data1_o   = tx[0];
  assign data2_o   = tx[0];
  assign data1_oe  = oe & ~split_pins;
  assign data2_oe  = oe & split_pins;

  AST_WR_SINGLE:       assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R3
  AST_WR_FULL_FRAME:   assert property (@(posedge clk) disable iff (!rst_n) reg_wr |-> (cnt == CNT_W'(FRAME))); // R3
  AST_NO_WR_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $past(cs_n) |-> !reg_wr); // R7
  AST_DRIVE_ON_READ:   assert property (@(posedge clk) disable iff (!rst_n) drive |-> cmd[RW_BIT]); // R4
  AST_TX_HOLD:         assert property (@(posedge clk) disable iff (!rst_n) !fall |=> $stable(tx)); // R4
  AST_CNT_BOUND:       assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_W'(FRAME)); // R8
  AST_IDLE_CLEAR:      assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> (cnt == '0 && !drive)); // R10
endmodule

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, split_pins = 1'b0, data1_i = 1'b0;
  logic data1_o, data1_oe, data2_o, data2_oe, reg_wr;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] bank [64];
  int checks = 0, fails = 0, wr_pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_reg_port u_dut (.*);

  assign reg_rdata = bank[reg_addr];
  always @(posedge clk) if (rst_n && reg_wr) begin
    bank[reg_addr] <= reg_wdata;
    wr_pulses++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // behavioural reference model
  int m_cnt = 0;
  logic [7:0] m_cmd = '0, m_dat = '0, m_tx = '0;
  logic m_drive = 1'b0, m_wr = 1'b0, m_prev = 1'b1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_drive = 1'b0; m_wr = 1'b0; m_prev = 1'b1;
    end else begin
      m_wr = 1'b0;
      if (cs_n) begin
        m_cnt = 0; m_drive = 1'b0;
      end else if (m_prev && !sclk && m_cnt < 16) begin
        if (m_cnt < 8) begin
          m_cmd[m_cnt] = data1_i;
          if (m_cnt == 7 && m_cmd[7]) begin m_tx = bank[m_cmd[5:0]]; m_drive = 1'b1; end
        end else if (m_cmd[7]) m_tx = m_tx >> 1;
        else begin
          m_dat[m_cnt-8] = data1_i;
          if (m_cnt == 15) m_wr = 1'b1;
        end
        m_cnt++;
      end
      m_prev = sclk;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 strobe vs model", {31'd0, reg_wr}, {31'd0, m_wr});
    if (m_wr) begin
      chk("R1 address vs model", {26'd0, reg_addr}, {26'd0, m_cmd[5:0]});
      chk("R3 wdata vs model", {24'd0, reg_wdata}, {24'd0, m_dat});
    end
    chk("R5 pin1 enable vs model", {31'd0, data1_oe}, {31'd0, m_drive && !cs_n && !split_pins});
    chk("R6 pin2 enable vs model", {31'd0, data2_oe}, {31'd0, m_drive && !cs_n && split_pins});
    if (m_drive && !cs_n)
      chk("R4 out bit vs model", {31'd0, split_pins ? data2_o : data1_o}, {31'd0, m_tx[0]});
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic xfer(input bit rd, input logic [5:0] a, input logic [7:0] wd,
                      input bit spare, input int nbits, output logic [7:0] got);
    logic [7:0] c;
    c = {rd, spare, a};
    got = '0;
    cs_n = 1'b0; tick(3);
    for (int i = 0; i < nbits; i++) begin
      if (i < 8) data1_i = c[i];
      else if (i < 16) data1_i = rd ? 1'b0 : wd[i-8];
      else data1_i = 1'b1;
      tick(2); sclk = 1'b0; tick(4);
      if (rd && i >= 7 && i < 15) got[i-7] = split_pins ? data2_o : data1_o;
      sclk = 1'b1; tick(2);
    end
    tick(2); cs_n = 1'b1; tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] got, pre;
    int p;
    for (int i = 0; i < 64; i++) bank[i] = 8'(i * 37 + 11);
    tick(5);
    chk("R9 reset pin1 enable", {31'd0, data1_oe}, 0);
    chk("R9 reset pin2 enable", {31'd0, data2_oe}, 0);
    chk("R9 reset strobe", {31'd0, reg_wr}, 0);
    rst_n = 1'b1; tick(3);

    xfer(1'b0, 6'h15, 8'hA6, 1'b0, 16, got);
    chk("R3 write lands", {24'd0, bank[6'h15]}, 32'hA6);
    xfer(1'b1, 6'h15, 8'h00, 1'b0, 16, got);
    chk("R4 readback shared pin", {24'd0, got}, 32'hA6);

    split_pins = 1'b1;
    pre = bank[6'h2A];
    xfer(1'b1, 6'h2A, 8'h00, 1'b0, 16, got);
    chk("R6 split read", {24'd0, got}, {24'd0, pre});
    xfer(1'b0, 6'h2B, 8'h5C, 1'b0, 16, got);
    xfer(1'b1, 6'h2B, 8'h00, 1'b0, 16, got);
    chk("R6 split write readback", {24'd0, got}, 32'h5C);
    split_pins = 1'b0;

    xfer(1'b0, 6'h07, 8'h3C, 1'b1, 16, got);
    chk("R2 spare bit ignored", {24'd0, bank[6'h07]}, 32'h3C);
    xfer(1'b1, 6'h07, 8'h00, 1'b1, 16, got);
    chk("R2 spare bit read", {24'd0, got}, 32'h3C);

    pre = bank[6'h10]; p = wr_pulses;
    xfer(1'b0, 6'h10, 8'hFF, 1'b0, 12, got);
    chk("R7 abort after 12 edges", wr_pulses, p);
    xfer(1'b0, 6'h10, 8'hFF, 1'b0, 15, got);
    chk("R7 abort after 15 edges", wr_pulses, p);
    xfer(1'b1, 6'h10, 8'h00, 1'b0, 16, got);
    chk("R7 register untouched", {24'd0, got}, {24'd0, pre});

    p = wr_pulses;
    xfer(1'b0, 6'h20, 8'h81, 1'b0, 20, got);
    chk("R8 single strobe", wr_pulses, p + 1);
    chk("R8 data unchanged by extra edges", {24'd0, bank[6'h20]}, 32'h81);

    p = wr_pulses; pre = bank[6'h00];
    data1_i = 1'b1;
    for (int i = 0; i < 16; i++) begin sclk = 1'b0; tick(3); sclk = 1'b1; tick(3); end
    chk("R10 no strobe while idle", wr_pulses, p);
    xfer(1'b1, 6'h00, 8'h00, 1'b0, 16, got);
    chk("R10 address 0 untouched", {24'd0, got}, {24'd0, pre});

    xfer(1'b0, 6'h3F, 8'hC3, 1'b0, 16, got);
    xfer(1'b1, 6'h3F, 8'h00, 1'b0, 16, got);
    chk("R1 top address", {24'd0, got}, 32'hC3);

    xfer(1'b1, 6'h3F, 8'h00, 1'b0, 10, got);
    chk("R5 enable off after release", {31'd0, data1_oe}, 0);
    chk("R5 pin2 off after release", {31'd0, data2_oe}, 0);

    tick(5);
    done = 1'b1;
    summary();
  end
endmodule